// File: doc/BRIEF.md
# Video Auxiliary Timing Pulse Generator

This block sits after a video sync counter chain and turns the current horizontal tick position, the line number and the index of the field within a four-field cycle into the auxiliary pulses that a camera or test-signal source needs next to its composite sync. It makes horizontal drive, vertical drive, a clamp pulse, a burst key with burst held off on a field-dependent group of lines, a white measurement pulse and an identification pulse. A one-bit system select picks between the 625-line and the 525-line line tables.

A set-identification strobe lets the surrounding system correct the field sequence. Once the strobe has been held high long enough to count as valid, its leading edge inverts an internal field-sequence flag. That flag swaps the first and third fields, and the second and fourth, for every field-dependent decision. All pulse outputs are registered and move only on clock edges where the tick enable is high, so they change in step with the counter values they decode.

Top module: `vid_aux_pulse_gen`

## Requirements
- R1: With S the sync tick position (parameter SYNC_POS, default 8), hd_o is high on every line for tick positions S-4 to S+31 inclusive (36 ticks).
- R2: clp_o is high for tick positions S+8 to S+19 inclusive (12 ticks) on every line.
- R3: bk_o is high for tick positions S+28 to S+39 inclusive (12 ticks) on every line that is not burst-suppressed, and is never high together with clp_o.
- R4: With sys_525 = 0 (625 lines, numbered 1 to 625) and effective field 0, 1, 2, 3, burst is suppressed on lines 623 to 6, 310 to 318, 622 to 5 and 311 to 319 respectively, wrapping through line 625.
- R5: With sys_525 = 1 (525 lines, numbered 1 to 525), burst is suppressed on lines 523 to 6 in effective fields 0 and 2 and on lines 261 to 269 in effective fields 1 and 3.
- R6: vd_o is high for the whole of lines 1 to 10 when sys_525 = 0 and lines 1 to 6 when sys_525 = 1, and low on all other lines.
- R7: wmp_o is high for tick positions S+172 to S+183 inclusive, only on lines 163 to 173 and 475 to 485 (sys_525 = 0) or lines 134 to 143 and 396 to 405 (sys_525 = 1).
- R8: id_o is high for tick positions S+8 to S+67 inclusive (60 ticks), only on lines 7 to 15 and 320 to 328 (sys_525 = 0) or lines 8 to 22 and 271 to 285 (sys_525 = 1).
- R9: fseq_o inverts once when si_in has been sampled high on SI_MIN_CYC consecutive clock edges (default 40, i.e. 800 ns at 50 MHz); shorter pulses leave it unchanged, a longer pulse toggles it only once, and while fseq_o = 1 the effective field is field_idx XOR 2.
- R10: After reset all pulse outputs and fseq_o are 0; the pulse outputs take the decode of the presented position on a clock edge where tick_en = 1 and hold their values on edges where tick_en = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Tick enable; outputs update only on enabled edges |
| h_pos | input | H_W (9) | Tick position within the line, 0 to 319 |
| line_num | input | L_W (10) | Line number within the frame, starting at 1 |
| field_idx | input | 2 | Field index 0 to 3 within the four-field cycle |
| sys_525 | input | 1 | System select: 0 = 625-line tables, 1 = 525-line tables |
| si_in | input | 1 | Set-identification strobe, active high |
| hd_o | output | 1 | Horizontal drive |
| vd_o | output | 1 | Vertical drive |
| clp_o | output | 1 | Clamp pulse |
| bk_o | output | 1 | Burst key with burst suppression |
| wmp_o | output | 1 | White measurement pulse |
| id_o | output | 1 | Identification pulse |
| fseq_o | output | 1 | Field-sequence flag |

## Verification
A wrong line table or a wrong field mapping shows as a burst key present or missing on one specific line of one field, so the bench sweeps every line of every field in both systems and a fault appears on the first tick of the offending line. A wrong horizontal offset shifts an edge by whole ticks and is caught by a full tick scan of a line. A fault in the strobe filter shows at fseq_o within a clock or two after the strobe qualifies, and indirectly one line later as burst moving to the swapped field's lines.

// File: rtl/vap_pkg.sv
package vap_pkg;

  // horizontal pulse indices
  localparam int NPULSE = 5;
  localparam int PI_HD  = 0;
  localparam int PI_CLP = 1;
  localparam int PI_BK  = 2;
  localparam int PI_WMP = 3;
  localparam int PI_ID  = 4;

  // offset of each pulse start from the sync leading edge, and its width, in ticks
  localparam int PULSE_OFS [NPULSE] = '{-4, 8, 28, 172, 8};
  localparam int PULSE_LEN [NPULSE] = '{36, 12, 12, 12, 60};

  // line tables, index 0 = 625-line system, 1 = 525-line system
  localparam int VD_LAST    [2] = '{10, 6};
  localparam int WMP1_FIRST [2] = '{163, 134};
  localparam int WMP1_LAST  [2] = '{173, 143};
  localparam int WMP2_FIRST [2] = '{475, 396};
  localparam int WMP2_LAST  [2] = '{485, 405};
  localparam int ID1_FIRST  [2] = '{7, 8};
  localparam int ID1_LAST   [2] = '{15, 22};
  localparam int ID2_FIRST  [2] = '{320, 271};
  localparam int ID2_LAST   [2] = '{328, 285};

  // burst suppression window per system and effective field (may wrap)
  localparam int SUPP_FIRST [2][4] = '{'{623, 310, 622, 311}, '{523, 261, 523, 261}};
  localparam int SUPP_LAST  [2][4] = '{'{6, 318, 5, 319},     '{6, 269, 6, 269}};

  // true when v lies in [lo, lo+len)
  function automatic logic span_hit(input int v, input int lo, input int len);
    return (v >= lo) && (v < lo + len);
  endfunction

  // inclusive line range; a range whose first exceeds its last wraps through frame end
  function automatic logic line_hit(input int l, input int first, input int last);
    if (first <= last) return (l >= first) && (l <= last);
    else               return (l >= first) || (l <= last);
  endfunction

endpackage

// File: rtl/vap_hdec.sv
module vap_hdec
  import vap_pkg::*;
#(
  parameter int H_W      = 9,
  parameter int SYNC_POS = 8
) (
  input  logic [H_W-1:0]    h_pos,
  output logic [NPULSE-1:0] hwin
);

  for (genvar g = 0; g < NPULSE; g++) begin : g_win
    assign hwin[g] = span_hit(int'(h_pos), SYNC_POS + PULSE_OFS[g], PULSE_LEN[g]);
  end

endmodule

// File: rtl/vap_vdec.sv
module vap_vdec
  import vap_pkg::*;
#(
  parameter int L_W = 10
) (
  input  logic [L_W-1:0] line_num,
  input  logic [1:0]     field_eff,
  input  logic           sys_525,
  output logic           vd_line,
  output logic           supp_line,
  output logic           wmp_line,
  output logic           id_line
);

  always_comb begin
    int l;
    int s;
    int f;
    l = int'(line_num);
    s = sys_525 ? 1 : 0;
    f = int'(field_eff);
    vd_line   = (l >= 1) && (l <= VD_LAST[s]);
    supp_line = line_hit(l, SUPP_FIRST[s][f], SUPP_LAST[s][f]);
    wmp_line  = line_hit(l, WMP1_FIRST[s], WMP1_LAST[s]) ||
                line_hit(l, WMP2_FIRST[s], WMP2_LAST[s]);
    id_line   = line_hit(l, ID1_FIRST[s], ID1_LAST[s]) ||
                line_hit(l, ID2_FIRST[s], ID2_LAST[s]);
  end

endmodule

// File: rtl/vap_si_filter.sv
module vap_si_filter #(
  parameter int MIN_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic si_in,
  output logic fseq
);

  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(MIN_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] hi_cnt;
  logic          qualify;

  // the strobe becomes valid on the edge that completes MIN_CYC high samples
  assign qualify = si_in && (hi_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      fseq   <= 1'b0;
    end else begin
      if (!si_in)                hi_cnt <= '0;
      else if (hi_cnt != CNT_FULL) hi_cnt <= hi_cnt + 1'b1;
      if (qualify) fseq <= ~fseq;
    end
  end

  // R9: the flag only moves while the strobe is held high
  assert_fseq_needs_si_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fseq) |-> $past(si_in));

  // R9: a toggle is followed by no second toggle while the strobe stays high
  assert_single_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (qualify && si_in) |=> (si_in |-> !qualify));

endmodule

// File: rtl/vid_aux_pulse_gen.sv
module vid_aux_pulse_gen
  import vap_pkg::*;
#(
  parameter int H_W        = 9,
  parameter int L_W        = 10,
  parameter int SYNC_POS   = 8,
  parameter int SI_MIN_CYC = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic [H_W-1:0] h_pos,
  input  logic [L_W-1:0] line_num,
  input  logic [1:0]     field_idx,
  input  logic           sys_525,
  input  logic           si_in,
  output logic           hd_o,
  output logic           vd_o,
  output logic           clp_o,
  output logic           bk_o,
  output logic           wmp_o,
  output logic           id_o,
  output logic           fseq_o
);

  logic [NPULSE-1:0] hwin;
  logic [1:0]        field_eff;
  logic              vd_line, supp_line, wmp_line, id_line;
  logic              fseq;

  vap_hdec #(.H_W(H_W), .SYNC_POS(SYNC_POS)) u_hdec (
    .h_pos (h_pos),
    .hwin  (hwin)
  );

  vap_si_filter #(.MIN_CYC(SI_MIN_CYC)) u_si (
    .clk   (clk),
    .rst_n (rst_n),
    .si_in (si_in),
    .fseq  (fseq)
  );

  // the field-sequence flag swaps fields 0<->2 and 1<->3
  assign field_eff = field_idx ^ {fseq, 1'b0};

  vap_vdec #(.L_W(L_W)) u_vdec (
    .line_num  (line_num),
    .field_eff (field_eff),
    .sys_525   (sys_525),
    .vd_line   (vd_line),
    .supp_line (supp_line),
    .wmp_line  (wmp_line),
    .id_line   (id_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd_o  <= 1'b0;
      vd_o  <= 1'b0;
      clp_o <= 1'b0;
      bk_o  <= 1'b0;
      wmp_o <= 1'b0;
      id_o  <= 1'b0;
    end else if (tick_en) begin
      hd_o  <= hwin[PI_HD];
      vd_o  <= vd_line;
      clp_o <= hwin[PI_CLP];
      bk_o  <= hwin[PI_BK] && !supp_line;
      wmp_o <= hwin[PI_WMP] && wmp_line;
      id_o  <= hwin[PI_ID] && id_line;
    end
  end

  assign fseq_o = fseq;

  // R10: outputs hold on edges without a tick
  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable({hd_o, vd_o, clp_o, bk_o, wmp_o, id_o}));

  // R3: burst key and clamp never overlap
  assert_bk_clp_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bk_o && clp_o));

  // R4: a suppressed line yields no burst key
  assert_supp_blocks_bk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && supp_line) |=> !bk_o);

  // R7: no measurement pulse outside its line ranges
  assert_wmp_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wmp_line) |=> !wmp_o);

  // R8: no identification pulse outside its line ranges
  assert_id_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !id_line) |=> !id_o);

  // R6: vertical drive follows its line range on every tick
  assert_vd_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (vd_o == $past(vd_line)));

endmodule

// File: tb/tb_vid_aux_pulse_gen.sv
module tb_vid_aux_pulse_gen;

  localparam int S = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [8:0] h_pos = '0;
  logic [9:0] line_num = 10'd1;
  logic [1:0] field_idx = '0;
  logic       sys_525 = 1'b0;
  logic       si_in = 1'b0;
  logic hd_o, vd_o, clp_o, bk_o, wmp_o, id_o, fseq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_fs = 0;

  always #10 clk = ~clk;

  vid_aux_pulse_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .h_pos(h_pos),
    .line_num(line_num), .field_idx(field_idx), .sys_525(sys_525), .si_in(si_in),
    .hd_o(hd_o), .vd_o(vd_o), .clp_o(clp_o), .bk_o(bk_o), .wmp_o(wmp_o),
    .id_o(id_o), .fseq_o(fseq_o)
  );

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b (h=%0d line=%0d field=%0d sys525=%0b)",
               req, what, got, exp, h_pos, line_num, field_idx, sys_525);
    end
  endtask

  // l counted from 1; true if l is within cnt lines starting at first, modulo total
  function automatic bit in_run(int l, int first, int cnt, int total);
    return ((l - first + total) % total) < cnt;
  endfunction

  function automatic bit m_hd(int h);  int d = h - S; return d >= -4 && d < 32;  endfunction
  function automatic bit m_clp(int h); int d = h - S; return d >= 8 && d < 20;   endfunction
  function automatic bit m_bkh(int h); int d = h - S; return d >= 28 && d < 40;  endfunction
  function automatic bit m_wh(int h);  int d = h - S; return d >= 172 && d < 184; endfunction
  function automatic bit m_ih(int h);  int d = h - S; return d >= 8 && d < 68;   endfunction

  function automatic bit m_supp(int l, int f, bit n525, bit fs);
    int ef = fs ? (f ^ 2) : f;
    int tot = n525 ? 525 : 625;
    int first;
    if (n525) first = (ef % 2 == 0) ? 523 : 261;
    else case (ef)
      0: first = 623;
      1: first = 310;
      2: first = 622;
      default: first = 311;
    endcase
    return in_run(l, first, 9, tot);
  endfunction

  function automatic bit m_vd(int l, bit n525);
    return l >= 1 && l <= (n525 ? 6 : 10);
  endfunction

  function automatic bit m_wl(int l, bit n525);
    if (n525) return in_run(l, 134, 10, 525) || in_run(l, 396, 10, 525);
    return in_run(l, 163, 11, 625) || in_run(l, 475, 11, 625);
  endfunction

  function automatic bit m_il(int l, bit n525);
    if (n525) return in_run(l, 8, 15, 525) || in_run(l, 271, 15, 525);
    return in_run(l, 7, 9, 625) || in_run(l, 320, 9, 625);
  endfunction

  task automatic apply(input int h, input int l, input int f);
    @(negedge clk);
    h_pos = 9'(h); line_num = 10'(l); field_idx = 2'(f);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R10", "reset hd", hd_o, 1'b0);
    check("R10", "reset vd", vd_o, 1'b0);
    check("R10", "reset clp", clp_o, 1'b0);
    check("R10", "reset bk", bk_o, 1'b0);
    check("R10", "reset wmp", wmp_o, 1'b0);
    check("R10", "reset id", id_o, 1'b0);
    check("R10", "reset fseq", fseq_o, 1'b0);
  endtask

  // full tick scan of chosen lines, every pulse checked (R1 R2 R3 R7 R8)
  task automatic t_hscan(input int l);
    sys_525 = 1'b0;
    for (int h = 0; h < 320; h++) begin
      apply(h, l, 0);
      check("R1", "hd", hd_o, m_hd(h));
      check("R2", "clp", clp_o, m_clp(h));
      check("R3", "bk", bk_o, m_bkh(h) && !m_supp(l, 0, 0, model_fs));
      check("R7", "wmp", wmp_o, m_wh(h) && m_wl(l, 0));
      check("R8", "id", id_o, m_ih(h) && m_il(l, 0));
      check("R6", "vd", vd_o, m_vd(l, 0));
    end
  endtask

  // every line of every field for one system (R4 R5 R6 R7 R8)
  task automatic t_lines(input bit n525);
    int tot = n525 ? 525 : 625;
    sys_525 = n525;
    for (int f = 0; f < 4; f++) begin
      for (int l = 1; l <= tot; l++) begin
        apply(S + 30, l, f);
        check(n525 ? "R5" : "R4", "bk suppression", bk_o, !m_supp(l, f, n525, model_fs));
        check("R6", "vd line", vd_o, m_vd(l, n525));
      end
    end
    for (int l = 1; l <= tot; l++) begin
      apply(S + 175, l, 0);
      check("R7", "wmp line", wmp_o, m_wl(l, n525));
      apply(S + 40, l, 0);
      check("R8", "id line", id_o, m_il(l, n525));
    end
  endtask

  task automatic si_pulse(input int k);
    @(negedge clk);
    si_in = 1'b1;
    repeat (k) @(negedge clk);
    si_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_si;
    sys_525 = 1'b0;
    si_pulse(39);
    check("R9", "short strobe ignored", fseq_o, 1'b0);
    apply(S + 30, 319, 1);
    check("R9", "bk unchanged after short strobe", bk_o, 1'b1);
    si_pulse(40);
    check("R9", "qualified strobe toggles", fseq_o, 1'b1);
    model_fs = 1;
    apply(S + 30, 319, 1);
    check("R9", "field 1 acts as field 3", bk_o, !m_supp(319, 1, 0, 1));
    apply(S + 30, 319, 3);
    check("R9", "field 3 acts as field 1", bk_o, !m_supp(319, 3, 0, 1));
    t_lines(1'b0);
    si_pulse(120);
    check("R9", "long strobe toggles once", fseq_o, 1'b0);
    model_fs = 0;
  endtask

  task automatic t_hold;
    sys_525 = 1'b0;
    apply(S, 50, 0);
    check("R10", "hd set before hold", hd_o, 1'b1);
    @(negedge clk);
    h_pos = 9'd100; line_num = 10'd3;
    repeat (3) @(negedge clk);
    check("R10", "hd held without tick", hd_o, 1'b1);
    check("R10", "vd held without tick", vd_o, 1'b0);
    apply(100, 3, 0);
    check("R10", "hd after tick", hd_o, 1'b0);
    check("R10", "vd after tick", vd_o, 1'b1);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hscan(50);
    t_hscan(170);
    t_hscan(10);
    t_lines(1'b0);
    t_lines(1'b1);
    t_si();
    t_hold();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

endmodule